// File: doc/BRIEF.md
# FIFO Flag Offset Register Loader

This block holds the two threshold offsets used by a FIFO's almost-empty and almost-full flag logic: an empty-side offset and a full-side offset, each wide enough to address any position in a buffer of `DEPTH` words. The flag comparison and the storage array live elsewhere. This block only keeps the offsets, loads them and returns them on request.

While master reset is high, the block samples a load-select input and a two-bit default selector. The load-select level fixes the way offsets are written until the next master reset: high means one bit per write, low means a whole word per write. The three inputs together also pick one of eight preset offsets. That preset is placed in both registers. There are two preset tables, and the block uses one of them depending on whether `DEPTH` is at most 2048 or larger.

After reset, software rewrites the offsets with write-clock edges on which both the write enable and the load strobe are high. It reads them back with read-clock edges on which both the read enable and the load strobe are high. Readback comes out on the wide parallel output bus.

Top module: `flo_offset_loader`

## Requirements
- R1: The level of `ld` during master reset selects the write mode (1 = serial, 0 = parallel). That mode stays in force after reset, whatever `ld` does later, until the next master reset.
- R2: With `DEPTH` <= 2048, master reset loads both offsets from the code {`ld`,`fsel[1]`,`fsel[0]`} as follows: 010 gives 511, 001 gives 255, 000 gives 127, 011 gives 63, 100 gives 31, 110 gives 15, 101 gives 7, 111 gives 3.
- R3: With `DEPTH` > 2048, the same code maps as follows: 100 gives 1023, 010 gives 511, 001 gives 255, 000 gives 127, 011 gives 63, 110 gives 31, 101 gives 15, 111 gives 7.
- R4: After master reset, `empty_off` equals `full_off`, `q` is zero, and both the parallel write target and the readback target point at the empty offset.
- R5: In parallel mode, each write-clock edge with `wen` and `ld` high stores `din[OFF_W-1:0]` into one offset register. Successive writes alternate, starting with `empty_off`. Writes are accepted at any time after reset.
- R6: In serial mode, each write-clock edge with `wen` and `ld` high stores `sin` into one bit. Bits fill `empty_off` LSB first and then `full_off` LSB first. After the top bit of `full_off`, filling resumes at bit 0 of `empty_off`.
- R7: A write-clock edge without both `wen` and `ld` high leaves both offsets unchanged. In serial mode, `din` is ignored. In parallel mode, `sin` is ignored.
- R8: Each read-clock edge with `ren` and `ld` high loads `q` with the empty offset and then the full offset, alternating, zero-extended to `DATA_W` bits. On any other read-clock edge, `q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock; offset registers update on its rising edge |
| rclk | input | 1 | Read clock; readback bus updates on its rising edge |
| mrst | input | 1 | Synchronous active-high master reset |
| ld | input | 1 | Load strobe; also sampled as the mode select during reset |
| fsel | input | 2 | Default offset selector, sampled during reset |
| wen | input | 1 | Write enable, qualified by `ld` |
| ren | input | 1 | Read enable, qualified by `ld` |
| sin | input | 1 | Serial offset data bit |
| din | input | DATA_W | Parallel offset data; the low OFF_W bits are used |
| empty_off | output | OFF_W | Almost-empty offset |
| full_off | output | OFF_W | Almost-full offset |
| q | output | DATA_W | Readback bus, zero-extended offset |

## Verification
The serial wrap-around is the hardest state to reach. The bit counter is invisible, so the only evidence that filling has resumed at the empty offset is the value of the registers after more than 2*OFF_W serial writes. The bench therefore shifts a pseudo-random stream longer than both registers together. It compares the outputs after every bit against a model kept separately for each width.

Two instances, at 1024 and 4096 words, receive the same stimulus. A single sweep of all eight reset codes therefore covers both preset tables.

// File: rtl/flo_pkg.sv
package flo_pkg;

  typedef enum logic {
    MODE_PAR = 1'b0,
    MODE_SER = 1'b1
  } load_mode_e;

  // Preset offset picked by {load select, sel1, sel0}; big selects the deep table.
  function automatic int unsigned flo_default(input logic big, input logic ldsel,
                                              input logic [1:0] fs);
    int unsigned v;
    if (big) begin
      case ({ldsel, fs})
        3'b100:  v = 1023;
        3'b010:  v = 511;
        3'b001:  v = 255;
        3'b000:  v = 127;
        3'b011:  v = 63;
        3'b110:  v = 31;
        3'b101:  v = 15;
        default: v = 7;
      endcase
    end else begin
      case ({ldsel, fs})
        3'b010:  v = 511;
        3'b001:  v = 255;
        3'b000:  v = 127;
        3'b011:  v = 63;
        3'b100:  v = 31;
        3'b110:  v = 15;
        3'b101:  v = 7;
        default: v = 3;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/flo_wr.sv
module flo_wr
  import flo_pkg::*;
#(
  parameter int OFF_W = 10,
  parameter bit BIG   = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [1:0]       fsel,
  input  logic             wen,
  input  logic             sin,
  input  logic [OFF_W-1:0] din,
  output logic [OFF_W-1:0] empty_off,
  output logic [OFF_W-1:0] full_off
);

  localparam int NBITS = 2 * OFF_W;
  localparam int CW    = $clog2(NBITS);

  load_mode_e       mode;
  logic             ptr;
  logic [CW-1:0]    cnt;
  logic [OFF_W-1:0] n_mask, m_mask;
  logic [OFF_W-1:0] dflt;
  logic             wr_go;

  assign wr_go = wen && ld;
  assign dflt  = OFF_W'(flo_default(BIG, ld, fsel));

  // One-hot bit selects for the serial fill position
  always_comb begin
    for (int i = 0; i < OFF_W; i++) begin
      n_mask[i] = (cnt == CW'(i));
      m_mask[i] = (cnt == CW'(i + OFF_W));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= ld ? MODE_SER : MODE_PAR;
      empty_off <= dflt;
      full_off  <= dflt;
      ptr       <= 1'b0;
      cnt       <= '0;
    end else if (wr_go) begin
      if (mode == MODE_SER) begin
        empty_off <= (empty_off & ~n_mask) | ({OFF_W{sin}} & n_mask);
        full_off  <= (full_off & ~m_mask) | ({OFF_W{sin}} & m_mask);
        cnt       <= (cnt == CW'(NBITS - 1)) ? '0 : cnt + 1'b1;
      end else begin
        if (!ptr) empty_off <= din;
        else      full_off  <= din;
        ptr <= ~ptr;
      end
    end
  end

endmodule

// File: rtl/flo_rd.sv
module flo_rd #(
  parameter int OFF_W  = 10,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic              ren,
  input  logic [OFF_W-1:0]  empty_off,
  input  logic [OFF_W-1:0]  full_off,
  output logic [DATA_W-1:0] q
);

  logic sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      sel <= 1'b0;
    end else if (ren && ld) begin
      q   <= DATA_W'(sel ? full_off : empty_off);
      sel <= ~sel;
    end
  end

endmodule

// File: rtl/flo_offset_loader.sv
module flo_offset_loader #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 36,
  parameter int OFF_W  = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst,
  input  logic              ld,
  input  logic [1:0]        fsel,
  input  logic              wen,
  input  logic              ren,
  input  logic              sin,
  input  logic [DATA_W-1:0] din,
  output logic [OFF_W-1:0]  empty_off,
  output logic [OFF_W-1:0]  full_off,
  output logic [DATA_W-1:0] q
);

  localparam bit BIG = (DEPTH > 2048);

  flo_wr #(.OFF_W(OFF_W), .BIG(BIG)) u_wr (
    .clk       (wclk),
    .rst       (mrst),
    .ld        (ld),
    .fsel      (fsel),
    .wen       (wen),
    .sin       (sin),
    .din       (din[OFF_W-1:0]),
    .empty_off (empty_off),
    .full_off  (full_off)
  );

  flo_rd #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_rd (
    .clk       (rclk),
    .rst       (mrst),
    .ld        (ld),
    .ren       (ren),
    .empty_off (empty_off),
    .full_off  (full_off),
    .q         (q)
  );

endmodule

// File: rtl/flo_offset_loader_chk.sv
module flo_offset_loader_chk
  import flo_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 36,
  parameter int OFF_W  = $clog2(DEPTH)
) (
  input logic              wclk,
  input logic              rclk,
  input logic              mrst,
  input logic              ld,
  input logic [1:0]        fsel,
  input logic              wen,
  input logic              ren,
  input logic              sin,
  input logic [DATA_W-1:0] din,
  input logic [OFF_W-1:0]  empty_off,
  input logic [OFF_W-1:0]  full_off,
  input logic [DATA_W-1:0] q
);

  localparam bit BIG = (DEPTH > 2048);

  logic seen_w = 1'b0;
  logic live_w = 1'b0;
  logic seen_r = 1'b0;
  logic live_r = 1'b0;
  logic ser_c  = 1'b0;

  always_ff @(posedge wclk) begin
    seen_w <= seen_w | mrst;
    live_w <= seen_w && !mrst;
    if (mrst) ser_c <= ld;
  end

  always_ff @(posedge rclk) begin
    seen_r <= seen_r | mrst;
    live_r <= seen_r && !mrst;
  end

  // R2, R3 and R4: both offsets take the table preset selected during reset
  a_r2_reset_default: assert property (@(posedge wclk) disable iff (mrst)
    (seen_w && $past(mrst)) |->
      (empty_off == full_off &&
       empty_off == OFF_W'(flo_default(BIG, $past(ld), $past(fsel)))));

  a_r7_hold_unqualified: assert property (@(posedge wclk) disable iff (mrst)
    (live_w && !$past(wen && ld)) |-> ($stable(empty_off) && $stable(full_off)));

  // R5 and R6: a single write touches at most one of the two registers
  a_r5_single_target: assert property (@(posedge wclk) disable iff (mrst)
    live_w |-> ($stable(empty_off) || $stable(full_off)));

  a_r6_one_bit_per_write: assert property (@(posedge wclk) disable iff (mrst)
    (live_w && ser_c) |->
      ($countones({empty_off, full_off} ^ $past({empty_off, full_off})) <= 1));

  a_r8_zero_extend: assert property (@(posedge rclk) disable iff (mrst)
    live_r |-> (q[DATA_W-1:OFF_W] == '0));

  a_r8_q_hold: assert property (@(posedge rclk) disable iff (mrst)
    (live_r && !$past(ren && ld)) |-> $stable(q));

endmodule

bind flo_offset_loader flo_offset_loader_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .OFF_W(OFF_W)
) u_chk (.*);

// File: tb/flo_offset_loader_test.sv
module flo_offset_loader_test;

  localparam int CLK_P = 10;
  localparam int DW    = 36;

  logic wclk = 1'b0, rclk = 1'b0;
  always #(CLK_P/2) begin
    wclk = ~wclk;
    rclk = ~rclk;
  end

  logic          mrst = 1'b1, ld = 1'b0, wen = 1'b0, ren = 1'b0, sin = 1'b0;
  logic [1:0]    fsel = 2'b00;
  logic [DW-1:0] din  = '0;

  logic [9:0]    en0, fu0;
  logic [11:0]   en1, fu1;
  logic [DW-1:0] q0, q1;

  flo_offset_loader #(.DEPTH(1024), .DATA_W(DW)) uut (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .ld(ld), .fsel(fsel), .wen(wen),
    .ren(ren), .sin(sin), .din(din), .empty_off(en0), .full_off(fu0), .q(q0));

  flo_offset_loader #(.DEPTH(4096), .DATA_W(DW)) uut2 (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .ld(ld), .fsel(fsel), .wen(wen),
    .ren(ren), .sin(sin), .din(din), .empty_off(en1), .full_off(fu1), .q(q1));

  int n_run = 0, n_fail = 0;
  bit done  = 1'b0;

  // Bench models, one slot per instance (0: 1024 words, 1: 4096 words)
  int  wdt[2] = '{10, 12};
  longint mn[2], mm[2], mq[2];
  int  mcnt[2], mptr[2], rsel[2];
  bit  mser;

  function automatic longint exp_def(bit big, bit l, bit [1:0] f);
    int e;
    case ({l, f})
      3'b010:  e = 9;
      3'b001:  e = 8;
      3'b000:  e = 7;
      3'b011:  e = 6;
      3'b100:  e = 5;
      3'b110:  e = 4;
      3'b101:  e = 3;
      default: e = 2;
    endcase
    if (big) begin
      if ({l, f} == 3'b100) e = 10;
      else if (l) e = e + 1;
    end
    return (longint'(1) << e) - 1;
  endfunction

  task automatic chk(string r, string what, longint act, longint exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge wclk);
    @(negedge wclk);
  endtask

  task automatic compare_all(string r);
    chk(r, "uut empty_off", longint'(en0), mn[0]);
    chk(r, "uut full_off",  longint'(fu0), mm[0]);
    chk(r, "uut q",         longint'(q0),  mq[0]);
    chk(r, "uut2 empty_off", longint'(en1), mn[1]);
    chk(r, "uut2 full_off",  longint'(fu1), mm[1]);
    chk(r, "uut2 q",         longint'(q1),  mq[1]);
  endtask

  task automatic do_reset(bit l, bit [1:0] f);
    mrst = 1'b1; ld = l; fsel = f; wen = 1'b0; ren = 1'b0;
    step();
    step();
    mrst = 1'b0; ld = 1'b0;
    for (int k = 0; k < 2; k++) begin
      mn[k] = exp_def(k == 1, l, f);
      mm[k] = mn[k];
      mq[k] = 0; mcnt[k] = 0; mptr[k] = 0; rsel[k] = 0;
    end
    mser = l;
  endtask

  task automatic wr(bit s, logic [DW-1:0] d);
    ld = 1'b1; wen = 1'b1; sin = s; din = d;
    step();
    ld = 1'b0; wen = 1'b0;
    for (int k = 0; k < 2; k++) begin
      longint mask = (longint'(1) << wdt[k]) - 1;
      if (mser) begin
        if (mcnt[k] < wdt[k])
          mn[k] = (mn[k] & ~(longint'(1) << mcnt[k])) | (longint'(s) << mcnt[k]);
        else
          mm[k] = (mm[k] & ~(longint'(1) << (mcnt[k] - wdt[k])))
                | (longint'(s) << (mcnt[k] - wdt[k]));
        mcnt[k] = (mcnt[k] + 1) % (2 * wdt[k]);
      end else begin
        if (mptr[k] == 0) mn[k] = longint'(d) & mask;
        else              mm[k] = longint'(d) & mask;
        mptr[k] ^= 1;
      end
    end
  endtask

  task automatic rd();
    ld = 1'b1; ren = 1'b1;
    step();
    ld = 1'b0; ren = 1'b0;
    for (int k = 0; k < 2; k++) begin
      mq[k] = rsel[k] ? mm[k] : mn[k];
      rsel[k] ^= 1;
    end
  endtask

  // Unqualified activity: models stay unchanged
  task automatic stray(bit w, bit r, bit l, bit s, logic [DW-1:0] d);
    wen = w; ren = r; ld = l; sin = s; din = d;
    step();
    wen = 1'b0; ren = 1'b0; ld = 1'b0;
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    @(negedge wclk);

    // R2, R3, R4: sweep all eight reset codes on both table groups
    for (int c = 0; c < 8; c++) begin
      do_reset(c[2], c[1:0]);
      chk("R2", "small preset", longint'(en0), exp_def(1'b0, c[2], c[1:0]));
      chk("R3", "large preset", longint'(en1), exp_def(1'b1, c[2], c[1:0]));
      chk("R4", "uut both equal", longint'(fu0), longint'(en0));
      chk("R4", "uut2 both equal", longint'(fu1), longint'(en1));
      chk("R4", "q cleared", longint'(q0) + longint'(q1), 0);
    end

    // R5, R1: parallel mode, alternation starting at empty offset, upper din bits dropped
    do_reset(1'b0, 2'b00);
    wr(1'b1, 36'hF_FFFF_F155);
    compare_all("R5");
    wr(1'b0, 36'h0_0000_0A3C);
    compare_all("R5");
    // R7: wen without ld, ld without wen, and sin in parallel mode
    stray(1'b1, 1'b0, 1'b0, 1'b1, 36'h0_0000_0777);
    compare_all("R7");
    stray(1'b0, 1'b0, 1'b1, 1'b1, 36'h0_0000_0555);
    compare_all("R7");
    // R8: readback alternation and hold
    rd(); compare_all("R8");
    rd(); compare_all("R8");
    stray(1'b0, 1'b1, 1'b0, 1'b0, '0);
    compare_all("R8");
    rd(); compare_all("R8");
    // R5: reprogram after readback
    wr(1'b0, 36'h0_0000_0001);
    wr(1'b0, 36'h0_0000_0FFF);
    compare_all("R5");
    rd(); rd(); compare_all("R8");

    // R6, R1: serial mode, wrap-around after both registers fill
    do_reset(1'b1, 2'b11);
    lf = 16'hACE1;
    for (int b = 0; b < 60; b++) begin
      wr(lf[0], 36'hF_FFFF_FFFF);
      lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
      compare_all("R6");
    end
    // R7: stray parallel data and unqualified edges in serial mode
    stray(1'b1, 1'b0, 1'b0, 1'b1, 36'h0_0000_0000);
    compare_all("R7");
    rd(); rd(); rd(); compare_all("R8");

    // R1: mode set by a later reset replaces the earlier one
    do_reset(1'b0, 2'b01);
    wr(1'b1, 36'h0_0000_0321);
    compare_all("R1");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule